// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set and Clear

This block is a parameterised general-purpose I/O port, eight pins by default, controlled from a simple synchronous register bus. Every pin can be a software-controlled digital I/O or can be handed to a primary peripheral function. Software-controlled pins have a direction bit and an output latch. Peripheral-owned pins pass the peripheral's output and output-enable straight to the pad, and return the pad level to the peripheral.

The pad is modelled as three vectors: an input from the pad, an output level and an output enable. An external tri-state buffer is expected to use them. Software reads pin levels through a two-flop synchroniser. That read reports the real pad level for every software-owned pin, whether the pin is an input or an output. The output latch has its own read path.

Two extra registers change the output latch one bit at a time. One of them sets bits and the other clears them, so software can change single bits without a read-modify-write sequence. The port has no interrupt output.

Top module: `gpio_port`

## Requirements
- R1: Reset is synchronous and active-high. After reset the output latch and the direction register are zero. The function-select register equals the parameter `PRIMARY_DEFAULT`, where a 1 means the pin belongs to its peripheral.
- R2: A bus write to offset 0x0 loads the output latch. A read of offset 0x0 returns the latch contents, whatever level the pads are at.
- R3: Offset 0x1 holds the direction register, where bit value 1 means output. For a software-owned pin, `pad_oe` equals its direction bit and `pad_out` equals its latch bit.
- R4: A write to offset 0x2 sets each latch bit whose written bit is 1. Latch bits written with 0 keep their value.
- R5: A write to offset 0x3 clears each latch bit whose written bit is 0. Latch bits written with 1 keep their value. A read of offset 0x3 returns zero.
- R6: A read of offset 0x2 returns the synchronised pad level for each software-owned pin, whether it is an input or an output, and 0 for peripheral-owned pins. A pad change shows on the read data after the second rising clock edge.
- R7: When a function-select bit is 1, `pad_out` and `pad_oe` for that pin follow `per_out` and `per_oe`, and `per_in` follows `pad_in`. For pins whose select bit is 0, `per_in` is 0.
- R8: Offset 0x4 holds the function-select register. It is written and read back in full.
- R9: Offsets 0x5 to 0x7 read as zero. Writes to them change no register.
- R10: Registers update on the rising edge at which `bus_we` is high. Read data is a combinational function of `bus_addr` and register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data |
| pad_in | input | WIDTH | Level seen at each pad |
| pad_out | output | WIDTH | Level driven towards each pad |
| pad_oe | output | WIDTH | Output enable for each pad buffer |
| per_in | output | WIDTH | Pad level forwarded to the peripheral |
| per_out | input | WIDTH | Peripheral output level |
| per_oe | input | WIDTH | Peripheral output enable |

## Verification
Most internal faults in the output latch appear on `pad_out` in the cycle after the write, provided the pin is an output. They also appear at once on a read of offset 0x0. A bad set or clear merge corrupts neighbouring bits, so the bench writes masks that leave untouched bits at both 0 and 1. A fault in the synchroniser appears only in when a pad change becomes visible, so the bench samples the pin read before and after the second edge. A wrong select bit swaps which source drives the pad, and it also masks or unmasks bits of the pin read. Random mixes of owners and directions expose both effects at the next sample.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LATCH = 3'd0,
        REG_DIR   = 3'd1,
        REG_PIN   = 3'd2,
        REG_CLR   = 3'd3,
        REG_SEL   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic latch;
        logic dir;
        logic set;
        logic clr;
        logic sel;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s.latch = we && (addr == REG_LATCH);
        s.dir   = we && (addr == REG_DIR);
        s.set   = we && (addr == REG_PIN);
        s.clr   = we && (addr == REG_CLR);
        s.sel   = we && (addr == REG_SEL);
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

    // Counts settled cycles since reset so the latency check only starts once history exists
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)            warm <= '0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        p_two_edge_latency_r6: assert property (@(posedge clk) disable iff (rst)
            (warm == 2) |-> (q == $past(d, 2)));
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] PRIMARY_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  sel_q
);
    wr_strobe_t st;
    assign st = decode_write(we, addr);

    logic [WIDTH-1:0] latch_nxt;
    always_comb begin
        latch_nxt = latch_q;
        unique case (1'b1)
            st.latch: latch_nxt = wdata;
            st.set:   latch_nxt = latch_q | wdata;
            st.clr:   latch_nxt = latch_q & wdata;
            default:  latch_nxt = latch_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            sel_q   <= PRIMARY_DEFAULT;
        end else begin
            latch_q <= latch_nxt;
            if (st.dir) dir_q <= wdata;
            if (st.sel) sel_q <= wdata;
        end
    end

    p_set_never_clears_r4: assert property (@(posedge clk) disable iff (rst)
        st.set |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
    p_clr_never_sets_r5: assert property (@(posedge clk) disable iff (rst)
        st.clr |=> ((latch_q & ~$past(latch_q)) == '0));
    p_latch_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !(st.latch || st.set || st.clr) |=> $stable(latch_q));
    p_dir_holds_r3: assert property (@(posedge clk) disable iff (rst)
        !st.dir |=> $stable(dir_q));
    p_sel_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !st.sel |=> $stable(sel_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] per_in
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_out[i] = sel[i] ? per_out[i] : latch[i];
        assign pad_oe[i]  = sel[i] ? per_oe[i]  : dir[i];
        assign per_in[i]  = sel[i] & pad_in[i];
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] PRIMARY_DEFAULT = 8'hC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  per_in,
    input  logic [WIDTH-1:0]  per_out,
    input  logic [WIDTH-1:0]  per_oe
);
    logic [WIDTH-1:0] latch_q, dir_q, sel_q, pin_sync;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .PRIMARY_DEFAULT(PRIMARY_DEFAULT)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .latch_q(latch_q), .dir_q(dir_q), .sel_q(sel_q)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
        .sel(sel_q), .latch(latch_q), .dir(dir_q),
        .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_in(per_in)
    );

    always_comb begin
        case (bus_addr)
            REG_LATCH: bus_rdata = latch_q;
            REG_DIR:   bus_rdata = dir_q;
            REG_PIN:   bus_rdata = pin_sync & ~sel_q;
            REG_SEL:   bus_rdata = sel_q;
            default:   bus_rdata = '0;
        endcase
    end

    p_unused_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > REG_SEL) |-> (bus_rdata == '0));
    p_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_CLR) |-> (bus_rdata == '0));
    p_pin_read_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_PIN) |-> ((bus_rdata & sel_q) == '0));
    p_gpio_input_undriven_r3: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~sel_q & ~dir_q) == '0));
    p_per_in_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((per_in & ~sel_q) == '0));
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    localparam int W = 8;
    localparam logic [W-1:0] PRIM = 8'hC0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] addr = '0;
    logic we = 1'b0;
    logic [W-1:0] wdata = '0, rdata;
    logic [W-1:0] ext = 8'h5A, per_out = '0, per_oe = '0;
    logic [W-1:0] pad_out, pad_oe, per_in, pad_in;

    always #2.5 clk = ~clk;

    // Pad model: a driven pad reflects the driven level, otherwise the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port #(.WIDTH(W), .PRIMARY_DEFAULT(PRIM)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_in(per_in), .per_out(per_out), .per_oe(per_oe)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    logic [W-1:0] m_latch, m_dir, m_sel, r;

    function automatic logic [W-1:0] e_oe();
        return (m_sel & per_oe) | (~m_sel & m_dir);
    endfunction
    function automatic logic [W-1:0] e_out();
        return (m_sel & per_out) | (~m_sel & m_latch);
    endfunction
    function automatic logic [W-1:0] e_level();
        return (e_oe() & e_out()) | (~e_oe() & ext);
    endfunction
    function automatic logic [W-1:0] e_pin();
        return e_level() & ~m_sel;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        case (a)
            3'd0: m_latch = d;
            3'd1: m_dir = d;
            3'd2: m_latch = m_latch | d;
            3'd3: m_latch = m_latch & d;
            3'd4: m_sel = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        @(negedge clk);
        addr = a;
        #0.5 v = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] v;
        settle();
        chk({tag, " R3 pad_oe"}, pad_oe, e_oe());
        chk({tag, " R7 pad_out"}, pad_out, e_out());
        chk({tag, " R7 per_in"}, per_in, e_level() & m_sel);
        rd(3'd0, v); chk({tag, " R2 latch read"}, v, m_latch);
        rd(3'd1, v); chk({tag, " R3 dir read"}, v, m_dir);
        rd(3'd2, v); chk({tag, " R6 pin read"}, v, e_pin());
        rd(3'd4, v); chk({tag, " R8 sel read"}, v, m_sel);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_latch = '0; m_dir = '0; m_sel = PRIM;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, r); chk("R1 latch reset", r, 8'h00);
        rd(3'd1, r); chk("R1 dir reset", r, 8'h00);
        rd(3'd4, r); chk("R1 sel reset", r, PRIM);
        chk("R1 pad_oe reset", pad_oe, 8'h00);

        // R2 latch is independent of pad level
        wr(3'd0, 8'hA5);
        ext = 8'h00;
        settle();
        rd(3'd0, r); chk("R2 latch read", r, 8'hA5);
        chk("R3 inputs undriven", pad_oe, 8'h00);

        // R3 direction
        wr(3'd1, 8'h0F);
        chk("R3 pad_oe after dir", pad_oe, 8'h0F);
        chk("R3 pad_out latch", pad_out & 8'h0F, 8'h05);

        // R4 set, R5 clear
        wr(3'd2, 8'h50);
        rd(3'd0, r); chk("R4 set merge", r, 8'hF5);
        wr(3'd3, 8'hFE);
        rd(3'd0, r); chk("R5 clear merge", r, 8'hF4);
        rd(3'd3, r); chk("R5 clear reads zero", r, 8'h00);

        // R6 latency of pin read on input pins
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h00);
        ext = 8'h00;
        settle();
        rd(3'd2, r); chk("R6 pin low", r, 8'h00);
        ext = 8'hFF;
        #0.5 chk("R6 no change before edges", rdata, 8'h00);
        @(negedge clk); chk("R6 one edge", rdata, 8'h00);
        @(negedge clk); chk("R6 two edges", rdata, 8'hFF);

        // R6 output pins read back driven level
        wr(3'd0, 8'h3C);
        wr(3'd1, 8'hFF);
        settle();
        rd(3'd2, r); chk("R6 output pin read", r, 8'h3C);

        // R7 peripheral ownership
        per_out = 8'h06; per_oe = 8'h0C; ext = 8'hA0;
        wr(3'd4, 8'h0F);
        check_all("directed");

        // R9 unused offsets
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'h00);
        wr(3'd7, 8'hAA);
        check_all("R9 after unused writes");
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), r); chk("R9 unused read", r, 8'h00);
        end

        // Random mix, R10 timing implied by model update at the write edge
        for (int i = 0; i < 150; i++) begin
            wr(3'($urandom_range(0, 6)), 8'($urandom));
            ext = 8'($urandom);
            per_out = 8'($urandom);
            per_oe = 8'($urandom);
            check_all("R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule